// File: doc/BRIEF.md
# Edge/Level Interrupt Trigger Selector

This block turns sixteen raw interrupt lines into sixteen request outputs for a pair of cascaded eight-input interrupt controllers. Software picks, line by line, whether a request is latched on a rising transition or follows the line's level. The choices sit in two 8-bit control registers, one per controller. Both are reached through an 8-bit I/O port at two consecutive addresses.

Every raw line first passes through a two-flop synchronizer. In edge mode, a rising edge of the synchronized line sets a sticky pending bit. That bit holds the request high until the line's acknowledge input clears it. In level mode, the request output is the synchronized line itself. Five lines are wired to edge mode: lines 0, 1, 2, 8 and 13. Their control bits cannot be set by any write.

The register port uses plain single-cycle strobes. A write completes on the clock edge where `io_wr` is high. Read data is combinational and valid while `io_rd` is high. The port has no back-pressure and no wait states.

Top module: `irq_trigger_sel`

## Requirements
- R1: A write to address 0x04D0 updates the low register (bit n controls line n). A write to 0x04D1 updates the high register (bit n controls line 8+n). A write to any other address leaves both registers unchanged.
- R2: A control bit of 0 selects edge triggering for its line, and a bit of 1 selects level triggering.
- R3: After reset both registers read 0x00 and every request output is low.
- R4: Control bits for lines 0, 1, 2, 8 and 13 always read back as 0 and the lines behave as edge-triggered. This holds whatever value is written.
- R5: In edge mode, a raw input that goes high before clock edge k raises the request after edge k+2. The request then stays high after the input falls.
- R6: In level mode, the request follows the raw input two clock edges later, in both directions.
- R7: In edge mode, acknowledge high at a clock edge clears the pending request at that edge. In level mode, acknowledge does not lower a request whose input stays high.
- R8: After a line changes from level mode to edge mode, its request is low. It stays low while the input stays high, until a new rising edge arrives.
- R9: A read returns the selected register at address 0x04D0 or 0x04D1. A read of any other address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O address of the register access |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational, zero when not selected |
| irq_in | input | 16 | Raw interrupt lines, asynchronous |
| irq_ack | input | 16 | Per-line acknowledge, clears an edge request |
| irq_req | output | 16 | Conditioned request outputs |

## Verification
The assertions check three things on every cycle. They check that the hard-wired edge lines never hold a level bit, and that a write to a foreign address leaves the registers unchanged. They also check the pending bit's rules in edge mode: it is set by a synchronized rise, it stays sticky without acknowledge, it is cleared by acknowledge, and it is empty right after a switch from level mode.

The exact latencies need the bench's directed scenarios: two edges for level mode and three for edge mode. So do the read-back values after masked writes, acknowledge having no effect in level mode, and the absence of a spurious request after a mode change while an input is held high.

// File: rtl/irq_trig_pkg.sv
package irq_trig_pkg;
  localparam int unsigned BANK_W   = 8;
  localparam int unsigned N_BANKS  = 2;
  localparam int unsigned N_LINES  = BANK_W * N_BANKS;
  localparam int unsigned IO_AW    = 16;
  localparam logic [IO_AW-1:0]   CTL_BASE  = 16'h04D0;
  // lines 0,1,2,8,13 are hard-wired to edge mode
  localparam logic [N_LINES-1:0] EDGE_ONLY = 16'h2107;
  typedef logic [BANK_W-1:0] bank_t;
endpackage

// File: rtl/irq_ctl_regs.sv
module irq_ctl_regs
  import irq_trig_pkg::*;
#(
  parameter int unsigned BANKS = N_BANKS,
  parameter int unsigned BW    = BANK_W,
  parameter int unsigned AW    = IO_AW,
  parameter logic [AW-1:0]       BASE  = CTL_BASE,
  parameter logic [BANKS*BW-1:0] FORCE = EDGE_ONLY
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [AW-1:0]       io_addr,
  input  logic                io_wr,
  input  logic                io_rd,
  input  logic [BW-1:0]       io_wdata,
  output logic [BW-1:0]       io_rdata,
  output logic [BANKS*BW-1:0] level_sel
);
  localparam int unsigned LINES = BANKS * BW;

  logic [LINES-1:0] sel_q;
  logic [BANKS-1:0] hit;

  always_comb begin
    for (int b = 0; b < BANKS; b++)
      hit[b] = (io_addr == BASE + AW'(b));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (io_wr) begin
      for (int b = 0; b < BANKS; b++)
        if (hit[b])
          sel_q[b*BW +: BW] <= io_wdata & ~FORCE[b*BW +: BW];
    end
  end

  always_comb begin
    io_rdata = '0;
    if (io_rd)
      for (int b = 0; b < BANKS; b++)
        if (hit[b]) io_rdata = sel_q[b*BW +: BW];
  end

  assign level_sel = sel_q;

  p_edge_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q & FORCE) == '0);

  p_foreign_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && hit == '0) |=> $stable(sel_q));
endmodule

// File: rtl/irq_line_cond.sv
module irq_line_cond #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_raw,
  input  logic ack,
  input  logic level_mode,
  output logic req
);
  // SYNC_STAGES synchronizer flops plus one history flop for edge detection
  logic [SYNC_STAGES:0] sh_q;
  logic                 pend_q;
  logic                 lvl;
  logic                 rise;

  assign lvl  = sh_q[SYNC_STAGES-1];
  assign rise = lvl & ~sh_q[SYNC_STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      pend_q <= 1'b0;
    end else begin
      sh_q <= {sh_q[SYNC_STAGES-1:0], irq_raw};
      if (level_mode)  pend_q <= 1'b0;
      else if (rise)   pend_q <= 1'b1;
      else if (ack)    pend_q <= 1'b0;
    end
  end

  assign req = level_mode ? lvl : pend_q;

  p_rise_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_mode && rise) |=> (pend_q || level_mode));

  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_mode && pend_q && !ack) |=> (pend_q || level_mode));

  p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_mode && pend_q && ack && !rise) |=> !pend_q);

  p_switch_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(level_mode) |-> !pend_q);
endmodule

// File: rtl/irq_trigger_sel.sv
module irq_trigger_sel
  import irq_trig_pkg::*;
#(
  parameter int unsigned LINES = N_LINES,
  parameter int unsigned BW    = BANK_W,
  parameter int unsigned AW    = IO_AW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    io_addr,
  input  logic             io_wr,
  input  logic             io_rd,
  input  logic [BW-1:0]    io_wdata,
  output logic [BW-1:0]    io_rdata,
  input  logic [LINES-1:0] irq_in,
  input  logic [LINES-1:0] irq_ack,
  output logic [LINES-1:0] irq_req
);
  localparam int unsigned BANKS = LINES / BW;

  logic [LINES-1:0] level_sel;

  irq_ctl_regs #(
    .BANKS(BANKS), .BW(BW), .AW(AW),
    .BASE(AW'(CTL_BASE)), .FORCE(LINES'(EDGE_ONLY))
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
    .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .level_sel(level_sel)
  );

  for (genvar i = 0; i < LINES; i++) begin : g_line
    irq_line_cond #(.SYNC_STAGES(2)) u_cond (
      .clk(clk), .rst_n(rst_n), .irq_raw(irq_in[i]), .ack(irq_ack[i]),
      .level_mode(level_sel[i]), .req(irq_req[i])
    );
  end
endmodule

// File: tb/test_irq_trigger_sel.sv
module test_irq_trigger_sel;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] io_addr;
  logic        io_wr, io_rd;
  logic [7:0]  io_wdata, io_rdata;
  logic [15:0] irq_in, irq_ack, irq_req;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  localparam logic [15:0] A_LO = 16'h04D0, A_HI = 16'h04D1;

  always #5 clk = ~clk;

  irq_trigger_sel i_irq_trigger_sel (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .irq_in(irq_in),
    .irq_ack(irq_ack), .irq_req(irq_req)
  );

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    tick();
    io_wr = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [15:0] a, logic [7:0] exp);
    io_addr = a; io_rd = 1'b1;
    #1;
    chk(tag, {8'h00, io_rdata}, {8'h00, exp});
    io_rd = 1'b0;
  endtask

  task automatic ack_line(int ln);
    irq_ack[ln] = 1'b1;
    tick();
    irq_ack[ln] = 1'b0;
  endtask

  task automatic t_reset;
    chk("R3 req after reset", irq_req, 16'h0000);
    rd_chk("R3 low reg reset", A_LO, 8'h00);
    rd_chk("R3 high reg reset", A_HI, 8'h00);
  endtask

  task automatic t_regs;
    wr(A_LO, 8'hFF);
    rd_chk("R4 low reg masks 0,1,2", A_LO, 8'hF8);
    wr(A_HI, 8'hFF);
    rd_chk("R4 high reg masks 8,13", A_HI, 8'hDE);
    wr(16'h04D2, 8'h00);
    rd_chk("R1 foreign write low", A_LO, 8'hF8);
    rd_chk("R1 foreign write high", A_HI, 8'hDE);
    rd_chk("R9 foreign read zero", 16'h04D2, 8'h00);
    wr(A_LO, 8'h00);
    wr(A_HI, 8'h00);
    rd_chk("R9 read after clear", A_LO, 8'h00);
  endtask

  task automatic t_edge;
    irq_in[3] = 1'b1;
    tick(2);
    chk("R5 edge not yet", irq_req, 16'h0000);
    tick();
    chk("R5 edge request", irq_req, 16'h0008);
    irq_in[3] = 1'b0;
    tick(4);
    chk("R5 edge sticky", irq_req, 16'h0008);
    ack_line(3);
    chk("R7 ack clears edge", irq_req, 16'h0000);
  endtask

  task automatic t_level;
    wr(A_LO, 8'h08);
    irq_in[3] = 1'b1;
    tick();
    chk("R6 level one edge", irq_req, 16'h0000);
    tick();
    chk("R6 level follows high", irq_req, 16'h0008);
    ack_line(3);
    tick();
    chk("R7 ack no effect level", irq_req, 16'h0008);
    irq_in[3] = 1'b0;
    tick(2);
    chk("R6 level follows low", irq_req, 16'h0000);
    wr(A_LO, 8'h00);
  endtask

  task automatic t_high_bank;
    wr(A_HI, 8'h02);
    rd_chk("R1 high reg bit1", A_HI, 8'h02);
    irq_in[9] = 1'b1;
    tick(2);
    chk("R1 line 9 level", irq_req, 16'h0200);
    irq_in[9] = 1'b0;
    tick(2);
    chk("R2 line 9 level low", irq_req, 16'h0000);
    wr(A_HI, 8'h00);
  endtask

  task automatic t_forced;
    wr(A_LO, 8'h07);
    wr(A_HI, 8'h21);
    rd_chk("R4 low forced read", A_LO, 8'h00);
    rd_chk("R4 high forced read", A_HI, 8'h00);
    foreach (irq_in[ln]) begin
      if (ln == 0 || ln == 13) begin
        irq_in[ln] = 1'b1;
        tick(2);
        chk("R4 forced line no level", irq_req, 16'h0000);
        tick();
        chk("R4 forced line edge", irq_req, 16'(1) << ln);
        irq_in[ln] = 1'b0;
        tick(3);
        chk("R4 forced line sticky", irq_req, 16'(1) << ln);
        ack_line(ln);
        chk("R7 forced ack", irq_req, 16'h0000);
      end
    end
  endtask

  task automatic t_switch;
    wr(A_LO, 8'h10);
    irq_in[4] = 1'b1;
    tick(2);
    chk("R8 level before switch", irq_req, 16'h0010);
    wr(A_LO, 8'h00);
    chk("R8 switch clears", irq_req, 16'h0000);
    tick(5);
    chk("R8 no spurious edge", irq_req, 16'h0000);
    irq_in[4] = 1'b0;
    tick(3);
    irq_in[4] = 1'b1;
    tick(3);
    chk("R8 new edge after switch", irq_req, 16'h0010);
    irq_in[4] = 1'b0;
    ack_line(4);
    chk("R7 ack after switch", irq_req, 16'h0000);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; io_addr = '0; io_wr = 1'b0; io_rd = 1'b0; io_wdata = '0;
    irq_in = '0; irq_ack = '0;
    tick(3);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_regs();
    t_edge();
    t_level();
    t_high_bank();
    t_forced();
    t_switch();
    done = 1'b1;
    summary();
  end
endmodule